// File: doc/BRIEF.md
# FM Channel Search and Preset Sequencer

This block is the digital tuning controller of a synthesizer-based FM receiver. On a completed configuration write it either jumps straight to a programmed 14-bit synthesizer divider word (preset) or walks the divider word across the selected broadcast band on a 100 kHz channel grid (search). After every new word it pulses a reload strobe, waits for the synthesizer to report lock (timed in 1 ms ticks), and then judges the channel. The judgement uses a 4-bit field-strength input against a programmable stop level, and an IF-count validity input.

The divider word for a channel is floor(4·(f ± 225 kHz)/32768 Hz). The plus sign applies to high-side injection and the minus sign to low-side injection. The word is held internally as a fixed-point value with 10 fractional bits. One 100 kHz step is therefore an exact increment of 12500. When an operation ends, the block raises a ready flag and may also raise a band-limit or IF-failure flag. It holds an audio-mute request as the rules below require. For the next 15 ticks it refuses new operations, so the status stays frozen while the host reads it.

Top module: `fm_tune_seq`

## Requirements
- R1: After synchronous reset, word_o is 0, and word_ld_o, busy_o, ready_o, band_flag_o and if_flag_o are all 0. mute_o equals afm_i.
- R2: An operation starts only on a cycle with cfg_wr_i=1 and wr_full_i=1 while the sequencer is idle. A write with wr_full_i=0 starts nothing and leaves word_o unchanged.
- R3: A preset (search_i=0) publishes start_word_i on word_o with exactly one word_ld_o pulse and ends with ready_o=1. mute_o is 1 for the whole time busy_o is 1.
- R4: A search first steps, then checks. Step k from base S gives word floor((S·1024 ± k·12500)/1024), with + when up_i=1 and − when up_i=0, and one word_ld_o pulse per step. The base S is start_word_i, or the current internal position when from_cur_i=1.
- R5: A search stops on the first step where level_i ≥ stop_lvl_i (equality passes) and if_ok_i=1. A step with a level pass but if_ok_i=0 is skipped when stop_on_if_i=0.
- R6: With stop_on_if_i=1, a step that passes the level check but fails the IF check ends the operation with if_flag_o=1. mute_o then stays 1 after completion.
- R7: The band window is inclusive. With band_jp_i=0 it is 87.5–108 MHz and with band_jp_i=1 it is 76–90 MHz, expressed in divider words for the injection side set by high_side_i. Example words are 13211 at the 108 MHz high-side edge, 13156 at the 108 MHz low-side edge and 9304 at the 76 MHz high-side edge. If the next step would fall outside the window, the search ends with band_flag_o=1 and word_o keeps the last word published.
- R8: Lock is sampled on tick_i cycles after the reload pulse. If 40 such ticks pass without lock, the operation ends with band_flag_o=1. Lock seen on the 40th tick still counts as lock.
- R9: After ready_o rises, completed writes are ignored for 15 ticks. After that they are accepted again.
- R10: A search with stop_on_if_i=0 and afm_i=0 leaves mute_o at 0. afm_i=1 forces mute_o to 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| wr_full_i | input | 1 | The write completed its whole byte |
| search_i | input | 1 | 1 = search, 0 = preset |
| up_i | input | 1 | Search direction, 1 = up, 0 = down |
| band_jp_i | input | 1 | 0 = 87.5–108 MHz, 1 = 76–90 MHz |
| high_side_i | input | 1 | 1 = high-side LO injection, 0 = low-side |
| from_cur_i | input | 1 | Search from current position instead of start_word_i |
| stop_on_if_i | input | 1 | Halt on a level pass with an IF fail |
| afm_i | input | 1 | Host audio mute |
| stop_lvl_i | input | 4 | Search stop level |
| start_word_i | input | 14 | Preset or search start divider word |
| tick_i | input | 1 | One-cycle 1 ms tick |
| lock_i | input | 1 | Synthesizer lock indication |
| level_i | input | 4 | Field-strength level |
| if_ok_i | input | 1 | IF count inside its valid window |
| word_o | output | 14 | Current divider word |
| word_ld_o | output | 1 | One-cycle reload pulse with each new word |
| busy_o | output | 1 | Operation in progress |
| ready_o | output | 1 | Operation finished |
| band_flag_o | output | 1 | Band edge reached or lock failed |
| if_flag_o | output | 1 | IF count invalid at the final channel |
| mute_o | output | 1 | Audio mute request |

## Verification
The lock timeout and lock arrival can fall on the same tick. When the 40th tick after a reload is also the first tick that sees lock, lock must win. The bench raises lock only after a counted number of ticks following the reload pulse. It runs one preset where lock appears on tick 40 and expects no band flag, and a second preset where lock would appear on tick 41 and expects the band flag. The search step that lands exactly on the band edge is also exercised, and that word must still be published.

// File: rtl/fmseq_pkg.sv
package fmseq_pkg;

    localparam int WORD_W     = 14;
    localparam int LVL_W      = 4;
    localparam int FRAC_W     = 10;
    localparam int REF_HZ     = 32768;
    localparam int IF_KHZ     = 225;
    localparam int STEP_KHZ   = 100;
    localparam int LOCK_TICKS = 40;
    localparam int HOLD_TICKS = 15;

    localparam int EU_LO_KHZ  = 87500;
    localparam int EU_HI_KHZ  = 108000;
    localparam int JP_LO_KHZ  = 76000;
    localparam int JP_HI_KHZ  = 90000;

    // divider word per kHz, scaled by 2^FRAC_W: 4*1000*1024/32768 = 125
    localparam int SCALE   = (4 * 1000 * (1 << FRAC_W)) / REF_HZ;
    localparam int STEP_FX = STEP_KHZ * SCALE;
    localparam int ACC_W   = WORD_W + FRAC_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_STEP,
        SQ_LOAD,
        SQ_WAIT,
        SQ_EVAL,
        SQ_HOLD
    } seq_state_e;

    typedef struct packed {
        logic search;
        logic up;
        logic band_jp;
        logic high_side;
        logic stop_on_if;
        lvl_t stop_lvl;
    } tune_cfg_t;

    function automatic word_t khz_to_word(input int khz, input bit high);
        int f;
        f = high ? (khz + IF_KHZ) : (khz - IF_KHZ);
        return word_t'((f * SCALE) >>> FRAC_W);
    endfunction

endpackage

// File: rtl/fmseq_edges.sv
module fmseq_edges
    import fmseq_pkg::*;
(
    input  logic  band_jp,
    input  logic  high_side,
    output word_t lo_word,
    output word_t hi_word
);
    word_t lo_tab [4];
    word_t hi_tab [4];

    for (genvar g = 0; g < 4; g++) begin : g_win
        localparam int LO_KHZ = (g >= 2) ? JP_LO_KHZ : EU_LO_KHZ;
        localparam int HI_KHZ = (g >= 2) ? JP_HI_KHZ : EU_HI_KHZ;
        localparam bit HIGH   = ((g % 2) == 1);
        assign lo_tab[g] = khz_to_word(LO_KHZ, HIGH);
        assign hi_tab[g] = khz_to_word(HI_KHZ, HIGH);
    end

    logic [1:0] sel;
    assign sel     = {band_jp, high_side};
    assign lo_word = lo_tab[sel];
    assign hi_word = hi_tab[sel];
endmodule

// File: rtl/fmseq_ticktimer.sv
module fmseq_ticktimer #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expire = en && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

    p_cnt_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT));
endmodule

// File: rtl/fmseq_acc.sv
module fmseq_acc
    import fmseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  seed,
    input  logic  keep,
    input  word_t start_word,
    input  logic  step,
    input  logic  up,
    input  logic  publish,
    input  word_t lo_word,
    input  word_t hi_word,
    output word_t word_o,
    output logic  ld_o,
    output logic  next_oob
);
    localparam int AW1 = ACC_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [AW1-1:0]   nx;
    word_t            nx_int;
    word_t            word_q;
    logic             ld_q;

    always_comb begin
        if (up) nx = {1'b0, acc_q} + AW1'(STEP_FX);
        else    nx = {1'b0, acc_q} - AW1'(STEP_FX);
        nx_int   = nx[ACC_W-1:FRAC_W];
        next_oob = nx[ACC_W] || (up ? (nx_int > hi_word) : (nx_int < lo_word));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            word_q <= '0;
            ld_q   <= 1'b0;
        end else begin
            ld_q <= publish;
            if (publish) word_q <= acc_q[ACC_W-1:FRAC_W];
            if (seed && !keep) acc_q <= {start_word, {FRAC_W{1'b0}}};
            else if (step)     acc_q <= nx[ACC_W-1:0];
        end
    end

    assign word_o = word_q;
    assign ld_o   = ld_q;

    p_word_with_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_q) |-> ld_q);
    p_step_in_band_r7: assert property (@(posedge clk) disable iff (rst)
        step |-> !next_oob);
endmodule

// File: rtl/fmseq_ctrl.sv
module fmseq_ctrl
    import fmseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trig,
    input  tune_cfg_t cfg_in,
    input  logic      tick,
    input  logic      lock,
    input  lvl_t      level,
    input  logic      if_ok,
    input  logic      ld,
    input  logic      oob,
    input  logic      lock_exp,
    input  logic      hold_exp,
    output tune_cfg_t cfg_q,
    output logic      seed,
    output logic      step,
    output logic      publish,
    output logic      lock_clr,
    output logic      lock_en,
    output logic      hold_clr,
    output logic      hold_en,
    output logic      busy,
    output logic      ready,
    output logic      band_flag,
    output logic      if_flag,
    output logic      mute_r
);
    seq_state_e st, nxt;
    logic fin, fin_band, fin_if, fin_keep, lvl_ok;

    always_comb begin
        nxt      = st;
        fin      = 1'b0;
        fin_band = 1'b0;
        fin_if   = 1'b0;
        fin_keep = 1'b0;
        seed     = 1'b0;
        step     = 1'b0;
        publish  = 1'b0;
        lock_clr = 1'b0;
        lvl_ok   = (level >= cfg_q.stop_lvl);
        case (st)
            SQ_IDLE: begin
                seed = trig;
                if (trig) nxt = cfg_in.search ? SQ_STEP : SQ_LOAD;
            end
            SQ_STEP: begin
                if (oob) begin
                    fin      = 1'b1;
                    fin_band = 1'b1;
                end else begin
                    step = 1'b1;
                    nxt  = SQ_LOAD;
                end
            end
            SQ_LOAD: begin
                publish  = 1'b1;
                lock_clr = 1'b1;
                nxt      = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (!ld && tick) begin
                    if (lock) begin
                        nxt = SQ_EVAL;
                    end else if (lock_exp) begin
                        fin      = 1'b1;
                        fin_band = 1'b1;
                    end
                end
            end
            SQ_EVAL: begin
                if (!cfg_q.search) begin
                    fin      = 1'b1;
                    fin_if   = !if_ok;
                    fin_keep = cfg_q.stop_on_if && lvl_ok && !if_ok;
                end else if (lvl_ok && if_ok) begin
                    fin = 1'b1;
                end else if (lvl_ok && cfg_q.stop_on_if) begin
                    fin      = 1'b1;
                    fin_if   = 1'b1;
                    fin_keep = 1'b1;
                end else begin
                    nxt = SQ_STEP;
                end
            end
            SQ_HOLD: begin
                if (hold_exp) nxt = SQ_IDLE;
            end
            default: nxt = SQ_IDLE;
        endcase
        if (fin) nxt = SQ_HOLD;
        hold_clr = fin;
    end

    assign lock_en = (st == SQ_WAIT) && !ld && tick && !lock;
    assign hold_en = (st == SQ_HOLD) && tick;
    assign busy    = (st != SQ_IDLE) && (st != SQ_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            cfg_q     <= '0;
            ready     <= 1'b0;
            band_flag <= 1'b0;
            if_flag   <= 1'b0;
            mute_r    <= 1'b0;
        end else begin
            st <= nxt;
            if (st == SQ_IDLE && trig) begin
                cfg_q     <= cfg_in;
                ready     <= 1'b0;
                band_flag <= 1'b0;
                if_flag   <= 1'b0;
                mute_r    <= !cfg_in.search || cfg_in.stop_on_if;
            end
            if (fin) begin
                ready     <= 1'b1;
                band_flag <= fin_band;
                if_flag   <= fin_if;
                mute_r    <= fin_keep;
            end
        end
    end

    p_preset_muted_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !cfg_q.search) |-> mute_r);
    p_ready_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
        !(ready && busy));
    p_flag_needs_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (band_flag || if_flag) |-> ready);
    p_hold_blocks_start_r9: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_HOLD && !hold_exp) |=> !busy);
endmodule

// File: rtl/fm_tune_seq.sv
module fm_tune_seq
    import fmseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr_i,
    input  logic        wr_full_i,
    input  logic        search_i,
    input  logic        up_i,
    input  logic        band_jp_i,
    input  logic        high_side_i,
    input  logic        from_cur_i,
    input  logic        stop_on_if_i,
    input  logic        afm_i,
    input  logic [3:0]  stop_lvl_i,
    input  logic [13:0] start_word_i,
    input  logic        tick_i,
    input  logic        lock_i,
    input  logic [3:0]  level_i,
    input  logic        if_ok_i,
    output logic [13:0] word_o,
    output logic        word_ld_o,
    output logic        busy_o,
    output logic        ready_o,
    output logic        band_flag_o,
    output logic        if_flag_o,
    output logic        mute_o
);
    tune_cfg_t cfg_in, cfg_q;
    word_t     lo_word, hi_word;
    logic      seed, step, publish, lock_clr, lock_en, hold_clr, hold_en;
    logic      lock_exp, hold_exp, oob, mute_r, trig;

    assign trig   = cfg_wr_i && wr_full_i;
    assign cfg_in = '{search: search_i, up: up_i, band_jp: band_jp_i,
                      high_side: high_side_i, stop_on_if: stop_on_if_i,
                      stop_lvl: stop_lvl_i};

    fmseq_edges u_edges (
        .band_jp   (cfg_q.band_jp),
        .high_side (cfg_q.high_side),
        .lo_word   (lo_word),
        .hi_word   (hi_word)
    );

    fmseq_acc u_acc (
        .clk        (clk),
        .rst        (rst),
        .seed       (seed),
        .keep       (search_i && from_cur_i),
        .start_word (start_word_i),
        .step       (step),
        .up         (cfg_q.up),
        .publish    (publish),
        .lo_word    (lo_word),
        .hi_word    (hi_word),
        .word_o     (word_o),
        .ld_o       (word_ld_o),
        .next_oob   (oob)
    );

    fmseq_ticktimer #(.LIMIT(LOCK_TICKS)) u_lock_tmr (
        .clk    (clk),
        .rst    (rst),
        .clr    (lock_clr),
        .en     (lock_en),
        .expire (lock_exp)
    );

    fmseq_ticktimer #(.LIMIT(HOLD_TICKS)) u_hold_tmr (
        .clk    (clk),
        .rst    (rst),
        .clr    (hold_clr),
        .en     (hold_en),
        .expire (hold_exp)
    );

    fmseq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .cfg_in    (cfg_in),
        .tick      (tick_i),
        .lock      (lock_i),
        .level     (level_i),
        .if_ok     (if_ok_i),
        .ld        (word_ld_o),
        .oob       (oob),
        .lock_exp  (lock_exp),
        .hold_exp  (hold_exp),
        .cfg_q     (cfg_q),
        .seed      (seed),
        .step      (step),
        .publish   (publish),
        .lock_clr  (lock_clr),
        .lock_en   (lock_en),
        .hold_clr  (hold_clr),
        .hold_en   (hold_en),
        .busy      (busy_o),
        .ready     (ready_o),
        .band_flag (band_flag_o),
        .if_flag   (if_flag_o),
        .mute_r    (mute_r)
    );

    assign mute_o = afm_i || mute_r;

    p_afm_forces_mute_r10: assert property (@(posedge clk) disable iff (rst)
        afm_i |-> mute_o);
endmodule

// File: tb/fm_tune_seq_test.sv
module fm_tune_seq_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 0, wr_full = 0, search = 0, up = 0, band_jp = 0, high_side = 1;
    logic from_cur = 0, stop_on_if = 0, afm = 0;
    logic [3:0]  stop_lvl = 4'd5;
    logic [13:0] start_word = '0;
    logic tick_i, lock_i, if_ok_i;
    logic [3:0] level_i;
    logic [13:0] word_o;
    logic word_ld_o, busy_o, ready_o, band_flag_o, if_flag_o, mute_o;

    int n_run = 0, n_fail = 0;
    int lv_a = -1, lv_b = -1, bad_if = -1, lock_after = 0;
    int lk_cnt = 0, ld_cnt = 0, tdiv = 0;
    bit saw_mute, saw_unmute, done_flag = 0;

    always #10 clk = ~clk;

    fm_tune_seq uut (
        .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr), .wr_full_i(wr_full),
        .search_i(search), .up_i(up), .band_jp_i(band_jp), .high_side_i(high_side),
        .from_cur_i(from_cur), .stop_on_if_i(stop_on_if), .afm_i(afm),
        .stop_lvl_i(stop_lvl), .start_word_i(start_word), .tick_i(tick_i),
        .lock_i(lock_i), .level_i(level_i), .if_ok_i(if_ok_i),
        .word_o(word_o), .word_ld_o(word_ld_o), .busy_o(busy_o), .ready_o(ready_o),
        .band_flag_o(band_flag_o), .if_flag_o(if_flag_o), .mute_o(mute_o)
    );

    // tick every 4 clocks; lock after a programmed tick count since reload
    always_ff @(posedge clk) begin
        tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
        if (word_ld_o) begin
            lk_cnt <= 0;
            ld_cnt <= ld_cnt + 1;
        end else if (tick_i) begin
            lk_cnt <= lk_cnt + 1;
        end
    end
    assign tick_i  = (tdiv == 3);
    assign lock_i  = (lk_cnt >= lock_after);
    assign level_i = (int'(word_o) == lv_a || int'(word_o) == lv_b) ? 4'd9 : 4'd2;
    assign if_ok_i = (int'(word_o) != bad_if);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fire(input bit full);
        @(negedge clk);
        cfg_wr = 1; wr_full = full;
        @(negedge clk);
        cfg_wr = 0; wr_full = 0;
    endtask

    task automatic run_op(output int loads);
        int base = ld_cnt;
        saw_mute = 0; saw_unmute = 0;
        fire(1'b1);
        for (int n = 0; n < 20000 && busy_o; n++) begin
            if (mute_o) saw_mute = 1; else saw_unmute = 1;
            @(negedge clk);
        end
        loads = ld_cnt - base;
    endtask

    task automatic settle();
        repeat (80) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(word_o == 0 && !word_ld_o && !busy_o && !ready_o, "R1 outputs idle", word_o, 0);
        chk(!band_flag_o && !if_flag_o && !mute_o, "R1 flags clear", band_flag_o, 0);
    endtask

    task automatic t_preset();
        int l;
        search = 0; start_word = 14'd12246;
        run_op(l);
        chk(word_o == 12246, "R3 preset word", word_o, 12246);
        chk(l == 1 && ready_o, "R3 one reload then ready", l, 1);
        chk(saw_mute && !saw_unmute, "R3 muted while busy", saw_unmute, 0);
        chk(!mute_o && !band_flag_o, "R3 unmuted after", mute_o, 0);
    endtask

    task automatic t_partial();
        int base = ld_cnt;
        settle();
        start_word = 14'd5000;
        fire(1'b0);
        repeat (10) @(negedge clk);
        chk(!busy_o && word_o == 12246 && ld_cnt == base, "R2 partial write ignored", word_o, 12246);
    endtask

    task automatic t_hold();
        int l, base;
        start_word = 14'd12000;
        run_op(l);
        base = ld_cnt;
        start_word = 14'd11000;
        fire(1'b1);
        repeat (8) @(negedge clk);
        chk(!busy_o && word_o == 12000 && ld_cnt == base, "R9 start ignored in hold", word_o, 12000);
        settle();
        run_op(l);
        chk(word_o == 11000, "R9 accepted after hold", word_o, 11000);
    endtask

    task automatic t_search_basic();
        int l;
        settle();
        search = 1; up = 1; band_jp = 0; high_side = 1; stop_lvl = 4'd9;
        start_word = 14'd12246; lv_a = 12282;
        run_op(l);
        chk(word_o == 12282 && l == 3, "R4 three up steps", word_o, 12282);
        chk(ready_o && !band_flag_o && !if_flag_o, "R5 stop at level equal", ready_o, 1);
        chk(!saw_mute && !mute_o, "R10 search unmuted", saw_mute, 0);
        stop_lvl = 4'd5;
    endtask

    task automatic t_from_cur();
        int l;
        settle();
        from_cur = 1; start_word = 14'd5000; lv_a = 12294;
        run_op(l);
        chk(word_o == 12294 && l == 1, "R4 continue from current", word_o, 12294);
        from_cur = 0;
    endtask

    task automatic t_if_skip();
        int l;
        settle();
        start_word = 14'd12246; lv_a = 12258; lv_b = 12282; bad_if = 12258;
        run_op(l);
        chk(word_o == 12282 && !if_flag_o, "R5 IF fail skipped", word_o, 12282);
    endtask

    task automatic t_if_stop();
        int l;
        settle();
        stop_on_if = 1;
        run_op(l);
        chk(word_o == 12258 && if_flag_o, "R6 halt on IF fail", word_o, 12258);
        chk(saw_mute && !saw_unmute && mute_o, "R6 mute kept", mute_o, 1);
        stop_on_if = 0; lv_a = -1; lv_b = -1; bad_if = -1;
    endtask

    task automatic t_band_down();
        int l;
        settle();
        band_jp = 1; up = 0; start_word = 14'd9330;
        run_op(l);
        chk(word_o == 9305 && l == 2 && band_flag_o, "R7 lower edge 76 MHz", word_o, 9305);
        band_jp = 0; up = 1;
    endtask

    task automatic t_edge_sides();
        int l;
        settle();
        high_side = 0; start_word = 14'd13150;
        run_op(l);
        chk(l == 0 && band_flag_o && word_o == 9305, "R7 low-side edge 13156", l, 0);
        settle();
        high_side = 1;
        run_op(l);
        chk(word_o == 13211 && l == 5 && band_flag_o, "R7 high-side edge inclusive", word_o, 13211);
    endtask

    task automatic t_lock();
        int l;
        settle();
        search = 0; start_word = 14'd10000; lock_after = 39; afm = 1;
        run_op(l);
        chk(ready_o && !band_flag_o, "R8 lock on 40th tick", band_flag_o, 0);
        chk(mute_o, "R10 afm forces mute", mute_o, 1);
        afm = 0;
        settle();
        lock_after = 40; start_word = 14'd10500;
        run_op(l);
        chk(ready_o && band_flag_o && word_o == 10500, "R8 lock timeout", band_flag_o, 1);
        lock_after = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_preset();
        t_partial();
        t_hold();
        t_search_basic();
        t_from_cur();
        t_if_skip();
        t_if_stop();
        t_band_down();
        t_edge_sides();
        t_lock();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule